// File: doc/BRIEF.md
# T1 Superframe Fs-Bit Data Link Receiver

This block sits after a T1 receive framer that runs superframe (D4) framing. For each frame the framer hands over the recovered framing bit and says whether it is a terminal-framing (Ft) bit or a signalling-framing (Fs) bit. The block looks only at the Fs bits. Each 72-frame multiframe carries 36 Fs bits: a 12-bit alignment pattern followed by 24 message bits. The block searches the Fs stream for that pattern and declares lock on the first complete match.

While locked, the block collects the 24 message bits. When the last message bit arrives, it copies all of them at once into three 8-bit registers and sets a latched update flag. The host clears the flag once it has read the registers, and it has one multiframe (about 9 ms) before the next refresh. After each message, the next twelve Fs bits must repeat the alignment pattern. If they do not, lock drops and the block goes back to searching. While unlocked, the registers keep their last contents and the flag is never set.

Top module: `fsdl_rx`

## Requirements
- R1: After a synchronous reset, all three message registers read zero, the update flag is 0 and the lock indication is 0.
- R2: Only a cycle with `frame_stb` high and `f_is_fs` high delivers a bit. Ft-marked frames have no effect on searching, lock or message contents, even when their bits spell the alignment pattern.
- R3: Lock is declared on the first match of the 12 most recent Fs bits against 000111000111, where the earliest received bit is the leftmost. `dl_locked` goes high in the cycle after the strobe that carries the twelfth pattern bit.
- R4: The 24 Fs bits that follow the pattern form the message. Message bit k (0 = first received) lands in register k/8 (0 = `msg_a`, 1 = `msg_b`, 2 = `msg_c`) at bit position 7-(k mod 8), so the first bit becomes `msg_a[7]`.
- R5: All three registers change together in the cycle after the strobe that carries the 24th message bit. Until then they hold the previous multiframe's values.
- R6: `dl_flag` sets in the same cycle as the register refresh. It then stays set until a cycle with `stat_clr` high clears it.
- R7: When `stat_clr` arrives in the same cycle as the last message bit, the flag ends up set.
- R8: After each message, the next 12 Fs bits are compared with the pattern. On a match the block stays locked and collects the next message. On a mismatch, `dl_locked` falls in the cycle after the twelfth bit.
- R9: While unlocked, the message registers do not change and the flag does not set, whatever Fs bits arrive.
- R10: A match needs twelve Fs bits received since reset. Fewer bits that happen to complete the pattern against the cleared history do not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe per received frame, qualifying `f_is_fs` and `f_bit` |
| f_is_fs | input | 1 | 1 when the framing bit of this frame is an Fs bit, 0 for Ft |
| f_bit | input | 1 | Value of the received framing bit |
| stat_clr | input | 1 | Host pulse that clears the update flag |
| msg_a | output | 8 | Message bits 0..7 (first received in bit 7) |
| msg_b | output | 8 | Message bits 8..15 |
| msg_c | output | 8 | Message bits 16..23 |
| dl_flag | output | 1 | Latched flag: registers refreshed since the last clear |
| dl_locked | output | 1 | Alignment pattern found and being tracked |

## Verification
The host clearing the flag and the block refreshing the registers can fall in the same cycle. The bench provokes this by raising `stat_clr` on exactly the strobe that carries the 24th message bit. It then judges that the flag reads set afterwards and that the registers hold the new message. A later clear-only pulse is checked to drop the flag, which confirms that the first result came from the priority rule and not from a stuck flag. The bench also walks a single 1 through all 24 message positions so that the bit mapping is covered in full.

// File: rtl/fsdl_pkg.sv
`timescale 1ns/1ps
package fsdl_pkg;
  localparam int              SYNC_LEN  = 12;
  localparam logic [11:0]     SYNC_WORD = 12'b000111000111;
  localparam int              FIELD_W   = 8;
  localparam int              FIELD_CNT = 3;

  typedef enum logic [1:0] {
    PH_HUNT,
    PH_MSG,
    PH_SYNC
  } phase_t;
endpackage

// File: rtl/fsdl_hunt.sv
`timescale 1ns/1ps
// Keeps the most recent Fs bits and flags a pattern match on the current bit.
module fsdl_hunt #(
  parameter int                  PAT_LEN = 12,
  parameter logic [PAT_LEN-1:0]  PATTERN = 12'b000111000111
) (
  input  logic clk,
  input  logic rst,
  input  logic fs_evt,
  input  logic f_bit,
  output logic match_now
);
  localparam int FILL_W = $clog2(PAT_LEN + 1);

  logic [PAT_LEN-1:0] hist;
  logic [PAT_LEN-1:0] hist_nxt;
  logic [FILL_W-1:0]  fill;
  logic               full_win;

  always_comb begin
    hist_nxt  = {hist[PAT_LEN-2:0], f_bit};
    full_win  = (fill >= FILL_W'(PAT_LEN - 1));
    match_now = fs_evt && full_win && (hist_nxt == PATTERN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      fill <= '0;
    end else if (fs_evt) begin
      hist <= hist_nxt;
      if (fill != FILL_W'(PAT_LEN))
        fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/fsdl_seq.sv
`timescale 1ns/1ps
// Multiframe phase tracker: hunt, collect message, verify next pattern.
module fsdl_seq
  import fsdl_pkg::*;
#(
  parameter int PAT_LEN  = 12,
  parameter int MSG_BITS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic fs_evt,
  input  logic match_now,
  output logic locked,
  output logic cap_en,
  output logic msg_done
);
  localparam int SPAN  = (MSG_BITS > PAT_LEN) ? MSG_BITS : PAT_LEN;
  localparam int CNT_W = $clog2(SPAN);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             last_msg;
  logic             last_pat;

  always_comb begin
    last_msg = (cnt == CNT_W'(MSG_BITS - 1));
    last_pat = (cnt == CNT_W'(PAT_LEN - 1));
    cap_en   = fs_evt && (phase == PH_MSG);
    msg_done = cap_en && last_msg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_HUNT;
      cnt    <= '0;
      locked <= 1'b0;
    end else if (fs_evt) begin
      case (phase)
        PH_HUNT: begin
          cnt <= '0;
          if (match_now) begin
            phase  <= PH_MSG;
            locked <= 1'b1;
          end
        end
        PH_MSG: begin
          if (last_msg) begin
            phase <= PH_SYNC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SYNC: begin
          if (last_pat) begin
            cnt <= '0;
            if (match_now) begin
              phase <= PH_MSG;
            end else begin
              phase  <= PH_HUNT;
              locked <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase  <= PH_HUNT;
          cnt    <= '0;
          locked <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fsdl_capture.sv
`timescale 1ns/1ps
// Stages message bits and loads all output fields in one cycle; owns the flag.
module fsdl_capture #(
  parameter int FIELD_W   = 8,
  parameter int FIELD_CNT = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cap_en,
  input  logic                             msg_done,
  input  logic                             f_bit,
  input  logic                             stat_clr,
  output logic [FIELD_CNT-1:0][FIELD_W-1:0] fields,
  output logic                             flag
);
  localparam int MSG_BITS = FIELD_W * FIELD_CNT;

  logic [MSG_BITS-2:0] stage;
  logic [MSG_BITS-1:0] whole;

  always_comb whole = {stage, f_bit};

  always_ff @(posedge clk) begin
    if (rst)
      stage <= '0;
    else if (cap_en)
      stage <= whole[MSG_BITS-2:0];
  end

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)
        fields[g] <= '0;
      else if (msg_done)
        fields[g] <= whole[MSG_BITS-1-g*FIELD_W -: FIELD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (msg_done)
      flag <= 1'b1;
    else if (stat_clr)
      flag <= 1'b0;
  end
endmodule

// File: rtl/fsdl_rx.sv
`timescale 1ns/1ps
module fsdl_rx
  import fsdl_pkg::*;
#(
  parameter int                   PAT_LEN = SYNC_LEN,
  parameter logic [PAT_LEN-1:0]   PATTERN = SYNC_WORD,
  parameter int                   REG_W   = FIELD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic             f_is_fs,
  input  logic             f_bit,
  input  logic             stat_clr,
  output logic [REG_W-1:0] msg_a,
  output logic [REG_W-1:0] msg_b,
  output logic [REG_W-1:0] msg_c,
  output logic             dl_flag,
  output logic             dl_locked
);
  localparam int N_REGS   = FIELD_CNT;
  localparam int MSG_BITS = REG_W * N_REGS;

  logic                         fs_evt;
  logic                         match_now;
  logic                         cap_en;
  logic                         msg_done;
  logic [N_REGS-1:0][REG_W-1:0] fields;

  always_comb fs_evt = frame_stb && f_is_fs;

  fsdl_hunt #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_hunt (
    .clk       (clk),
    .rst       (rst),
    .fs_evt    (fs_evt),
    .f_bit     (f_bit),
    .match_now (match_now)
  );

  fsdl_seq #(.PAT_LEN(PAT_LEN), .MSG_BITS(MSG_BITS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .fs_evt    (fs_evt),
    .match_now (match_now),
    .locked    (dl_locked),
    .cap_en    (cap_en),
    .msg_done  (msg_done)
  );

  fsdl_capture #(.FIELD_W(REG_W), .FIELD_CNT(N_REGS)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .msg_done (msg_done),
    .f_bit    (f_bit),
    .stat_clr (stat_clr),
    .fields   (fields),
    .flag     (dl_flag)
  );

  always_comb begin
    msg_a = fields[0];
    msg_b = fields[1];
    msg_c = fields[2];
  end
endmodule

// File: rtl/fsdl_rx_chk.sv
`timescale 1ns/1ps
module fsdl_rx_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_stb,
  input logic             f_is_fs,
  input logic             stat_clr,
  input logic [REG_W-1:0] msg_a,
  input logic [REG_W-1:0] msg_b,
  input logic [REG_W-1:0] msg_c,
  input logic             dl_flag,
  input logic             dl_locked
);
  // R2
  no_fs_lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(frame_stb && f_is_fs) |=> $stable(dl_locked));

  // R3
  lock_rise_on_fs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dl_locked) |-> $past(frame_stb && f_is_fs));

  // R8
  lock_fall_on_fs_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dl_locked) |-> $past(frame_stb && f_is_fs));

  // R9
  msg_change_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({msg_a, msg_b, msg_c}) |-> (dl_flag && $past(dl_locked)));

  // R5
  flag_rise_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dl_flag) |-> ($past(dl_locked) && dl_locked));

  // R6
  flag_latched_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(dl_flag) && !$past(stat_clr)) |-> dl_flag);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !(frame_stb && f_is_fs)) |=> !dl_flag);
endmodule

bind fsdl_rx fsdl_rx_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_stb (frame_stb),
  .f_is_fs   (f_is_fs),
  .stat_clr  (stat_clr),
  .msg_a     (msg_a),
  .msg_b     (msg_b),
  .msg_c     (msg_c),
  .dl_flag   (dl_flag),
  .dl_locked (dl_locked)
);

// File: tb/sim_fsdl_rx.sv
`timescale 1ns/1ps
module sim_fsdl_rx;
  localparam logic [11:0] PAT = 12'b000111000111;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic       f_is_fs = 1'b0;
  logic       f_bit = 1'b0;
  logic       stat_clr = 1'b0;
  logic [7:0] msg_a, msg_b, msg_c;
  logic       dl_flag, dl_locked;

  int   n_chk = 0;
  int   n_bad = 0;
  logic ft_tog = 1'b1;
  logic [23:0] cur = '0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  fsdl_rx u0 (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .f_is_fs(f_is_fs),
    .f_bit(f_bit), .stat_clr(stat_clr), .msg_a(msg_a), .msg_b(msg_b),
    .msg_c(msg_c), .dl_flag(dl_flag), .dl_locked(dl_locked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic isfs, input logic b, input logic clr);
    @(negedge clk);
    frame_stb = 1'b1; f_is_fs = isfs; f_bit = b; stat_clr = clr;
    @(negedge clk);
    frame_stb = 1'b0; stat_clr = 1'b0; f_bit = ~b;
  endtask

  task automatic fs(input logic b, input logic clr = 1'b0);
    frame(1'b0, ft_tog, 1'b0);
    ft_tog = ~ft_tog;
    frame(1'b1, b, clr);
  endtask

  task automatic send_pat(input logic [11:0] p);
    for (int i = 11; i >= 0; i--) fs(p[i]);
  endtask

  task automatic clear_flag();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  // sends a message, checks hold before the last bit and the refresh after it
  task automatic send_msg(input logic [23:0] m, input logic clr_last);
    for (int k = 0; k < 24; k++) begin
      fs(m[23-k], (k == 23) ? clr_last : 1'b0);
      if (k == 22)
        chk("R5 hold before last bit", {8'h0, msg_a, msg_b, msg_c}, {8'h0, cur});
    end
    chk("R4 msg_a", {24'h0, msg_a}, {24'h0, m[23:16]});
    chk("R4 msg_b", {24'h0, msg_b}, {24'h0, m[15:8]});
    chk("R4 msg_c", {24'h0, msg_c}, {24'h0, m[7:0]});
    chk("R6 flag set on refresh", {31'h0, dl_flag}, 32'h1);
    cur = m;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 msg", {8'h0, msg_a, msg_b, msg_c}, 32'h0);
    chk("R1 flag", {31'h0, dl_flag}, 32'h0);
    chk("R1 locked", {31'h0, dl_locked}, 32'h0);

    // R2: pattern on Ft bits only
    for (int i = 11; i >= 0; i--) frame(1'b0, PAT[i], 1'b0);
    chk("R2 Ft pattern ignored", {31'h0, dl_locked}, 32'h0);

    // R10: nine bits complete the pattern against cleared history
    for (int i = 8; i >= 0; i--) fs(PAT[i]);
    chk("R10 short history", {31'h0, dl_locked}, 32'h0);
    repeat (3) fs(1'b1);

    // R3: lock on twelfth bit exactly
    for (int i = 11; i >= 1; i--) fs(PAT[i]);
    chk("R3 not before 12th bit", {31'h0, dl_locked}, 32'h0);
    fs(PAT[0]);
    chk("R3 locked after 12th bit", {31'h0, dl_locked}, 32'h1);
    chk("R6 no flag at lock", {31'h0, dl_flag}, 32'h0);

    send_msg(24'hC3A55A, 1'b0);
    repeat (4) frame(1'b0, 1'b1, 1'b0);
    chk("R6 flag latched", {31'h0, dl_flag}, 32'h1);
    clear_flag();
    chk("R6 flag cleared", {31'h0, dl_flag}, 32'h0);

    // R4: walking one over all message positions
    for (int k = 0; k < 24; k++) begin
      send_pat(PAT);
      chk("R8 lock kept", {31'h0, dl_locked}, 32'h1);
      send_msg(24'h800000 >> k, 1'b0);
      clear_flag();
    end

    // R4: arithmetic patterns
    for (int i = 0; i < 8; i++) begin
      logic [23:0] m;
      m = 24'((i + 3) * 24'h13579B) ^ 24'h2468AC;
      send_pat(PAT);
      send_msg(m, 1'b0);
      clear_flag();
    end

    // R7: clear on the same strobe as the last message bit
    send_pat(PAT);
    send_msg(24'h0F1E2D, 1'b1);
    chk("R7 set wins over clear", {31'h0, dl_flag}, 32'h1);
    clear_flag();
    chk("R7 later clear works", {31'h0, dl_flag}, 32'h0);

    // R8: corrupted pattern at boundary
    for (int i = 11; i >= 1; i--) fs(PAT[i]);
    chk("R8 locked before bad bit", {31'h0, dl_locked}, 32'h1);
    fs(~PAT[0]);
    chk("R8 lock lost", {31'h0, dl_locked}, 32'h0);

    // R9: message bits while unlocked
    repeat (24) fs(1'b1);
    chk("R9 msg held", {8'h0, msg_a, msg_b, msg_c}, {8'h0, cur});
    chk("R9 no flag", {31'h0, dl_flag}, 32'h0);
    chk("R9 still unlocked", {31'h0, dl_locked}, 32'h0);

    // R3: relock and refresh
    send_pat(PAT);
    chk("R3 relock", {31'h0, dl_locked}, 32'h1);
    send_msg(24'h5AC396, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule